// File: doc/BRIEF.md
# Crosspoint Switch Configuration Controller

This block is the digital control front end of a 16-input by 5-output crosspoint switch. Configuration words arrive on a 5-bit parallel bus with a 3-bit address. Each word is written on a clock edge into one of eight 5-bit staging locations. When the update strobe goes low, a bank of level-sensitive output latches opens and picks up the staged words for the five outputs. Each output latch holds a 4-bit input select and an enable bit. These are decoded into 80 switch-control lines, one for each input/output pairing.

A chip-enable input, active low, must be asserted before anything can change. An asynchronous active-low reset turns every output off by clearing the five enable latches. The staged words and the latched selects are left as they were, so a later update restores the previous routing.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: While `ce_n` is 1, no storage changes. A clock edge with any `upd_n`, `addr` or `wdata` leaves staging and latches as they were.
- R2: On a rising `clk` edge with `ce_n`=0 and `upd_n`=1, `wdata` is stored in staging location `addr`. There are 8 locations of 5 bits each.
- R3: While `ce_n`=0 and `upd_n`=0, the output latches are transparent and follow staging locations 0 to 4. A clock edge in this state writes no staging location.
- R4: While `upd_n` is 1, writes to staging have no visible effect on `out_en` or `sw_ctrl`.
- R5: Staging location k (k = 0 to 4) controls output k. Bit 4 of the word is the enable, driven on `out_en[k]`, and bits 3:0 are the input select.
- R6: `sw_ctrl[k*16+s]` is 1 exactly when output k is enabled and its select equals s. Each output's 16-bit slice is therefore one-hot when enabled and all zero when disabled.
- R7: Locations 5 to 7 can be written but have no effect on any output.
- R8: When `rst_n` is 0, all bits of `out_en` and all bits of `sw_ctrl` are 0 at once, without waiting for a clock edge. Staged words and latched selects are kept.
- R9: After `rst_n` returns to 1, `out_en` stays 0 until a transfer (`ce_n`=0, `upd_n`=0) loads the staged enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for staging writes |
| rst_n | input | 1 | Asynchronous active-low clear of all output enables |
| ce_n | input | 1 | Active-low chip enable; 1 freezes all state |
| upd_n | input | 1 | 1 selects staging writes; 0 opens the output latches |
| addr | input | 3 | Staging location to write |
| wdata | input | 5 | Word to stage: bit 4 enable, bits 3:0 input select |
| sw_ctrl | output | 80 | Switch controls, index output*16 + input |
| out_en | output | 5 | Per-output enable |

## Verification
The bench first stages words with `upd_n` held high and confirms the switch lines do not move. This catches a design whose latches leak staging data before the transfer. It then sends writes with chip enable high, and clock edges with the latches open. A design that ignores `ce_n`, or that writes staging while the latches are open, shows new routing after the next transfer. Selects 0 and 15 and the disabled case are checked for each output to catch an off-by-one in the decoder or a missing enable gate. Writes to locations 5 to 7 are checked for no effect. Reset is pulsed between clock edges to check that the outputs clear at once. After reset is released, a plain transfer must bring back the old routing: a design whose reset also clears selects or staged words gives the wrong routing, and one that clears nothing leaves outputs on.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned XB_N_IN   = 16;
  localparam int unsigned XB_N_OUT  = 5;
  localparam int unsigned XB_ADDR_W = 3;
endpackage

// File: rtl/xbar_stage.sv
module xbar_stage #(
  parameter int unsigned N_OUT  = xbar_pkg::XB_N_OUT,
  parameter int unsigned ADDR_W = xbar_pkg::XB_ADDR_W,
  parameter int unsigned WORD_W = 5
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [WORD_W-1:0]         wr_word,
  output logic [N_OUT*WORD_W-1:0]   live_words
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_word;
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_tap
    assign live_words[k*WORD_W +: WORD_W] = slots[k];
  end
endmodule

// File: rtl/xbar_hold.sv
module xbar_hold #(
  parameter int unsigned N_OUT = xbar_pkg::XB_N_OUT,
  parameter int unsigned SEL_W = 4
) (
  input  logic                    rst_n,
  input  logic                    open,
  input  logic [N_OUT*(SEL_W+1)-1:0] words,
  output logic [N_OUT*SEL_W-1:0]  sel_q,
  output logic [N_OUT-1:0]        en_q
);
  localparam int unsigned WORD_W = SEL_W + 1;

  for (genvar k = 0; k < N_OUT; k++) begin : g_lat
    always_latch begin
      if (open) sel_q[k*SEL_W +: SEL_W] <= words[k*WORD_W +: SEL_W];
    end

    always_latch begin
      if (!rst_n)    en_q[k] <= 1'b0;
      else if (open) en_q[k] <= words[k*WORD_W + SEL_W];
    end
  end
endmodule

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int unsigned N_IN  = xbar_pkg::XB_N_IN,
  parameter int unsigned N_OUT = xbar_pkg::XB_N_OUT,
  parameter int unsigned SEL_W = $clog2(N_IN)
) (
  input  logic [N_OUT*SEL_W-1:0] sel,
  input  logic [N_OUT-1:0]       en,
  output logic [N_OUT*N_IN-1:0]  lines
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign lines[o*N_IN + i] = en[o] && (sel[o*SEL_W +: SEL_W] == SEL_W'(i));
    end
  end
endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl #(
  parameter int unsigned N_IN   = xbar_pkg::XB_N_IN,
  parameter int unsigned N_OUT  = xbar_pkg::XB_N_OUT,
  parameter int unsigned ADDR_W = xbar_pkg::XB_ADDR_W,
  localparam int unsigned SEL_W  = $clog2(N_IN),
  localparam int unsigned WORD_W = SEL_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_n,
  input  logic                    upd_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [WORD_W-1:0]       wdata,
  output logic [N_OUT*N_IN-1:0]   sw_ctrl,
  output logic [N_OUT-1:0]        out_en
);
  logic                      stage_we;
  logic                      latch_open;
  logic [N_OUT*WORD_W-1:0]   stage_q;
  logic [N_OUT*SEL_W-1:0]    sel_q;
  logic [N_OUT-1:0]          en_q;

  assign stage_we   = !ce_n && upd_n;
  assign latch_open = !ce_n && !upd_n;

  xbar_stage #(.N_OUT(N_OUT), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_stage (
    .clk(clk), .wr_en(stage_we), .wr_addr(addr), .wr_word(wdata),
    .live_words(stage_q)
  );

  xbar_hold #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_hold (
    .rst_n(rst_n), .open(latch_open), .words(stage_q),
    .sel_q(sel_q), .en_q(en_q)
  );

  xbar_decode #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_dec (
    .sel(sel_q), .en(en_q), .lines(sw_ctrl)
  );

  assign out_en = en_q;
endmodule

// File: rtl/xbar_cfg_chk.sv
module xbar_cfg_chk #(
  parameter int unsigned N_IN  = 16,
  parameter int unsigned N_OUT = 5,
  parameter int unsigned SEL_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ce_n,
  input logic                        upd_n,
  input logic [N_OUT*N_IN-1:0]       sw_ctrl,
  input logic [N_OUT-1:0]            out_en,
  input logic [N_OUT*(SEL_W+1)-1:0]  stage_q
);
  localparam int unsigned WORD_W = SEL_W + 1;

  // R1: chip enable high for a whole cycle freezes the outputs
  a_r1_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && $past(ce_n) && $past(rst_n)) |-> ($stable(sw_ctrl) && $stable(out_en)));

  // R4: update high keeps the enables from moving
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_n && $past(upd_n) && $past(rst_n)) |-> $stable(out_en));

  // R8: enables are clear whenever reset is asserted
  a_r8_rst_clear: assert property (@(posedge clk)
    !rst_n |-> (out_en == '0 && sw_ctrl == '0));

  for (genvar k = 0; k < N_OUT; k++) begin : g_k
    // R3: open latches track the staged enable bit
    a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !upd_n) |-> (out_en[k] == stage_q[k*WORD_W + SEL_W]));
    // R6: enabled output has exactly one switch line on
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      out_en[k] |-> ($countones(sw_ctrl[k*N_IN +: N_IN]) == 1));
    // R6: disabled output has no switch line on
    a_r6_off: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[k] |-> (sw_ctrl[k*N_IN +: N_IN] == '0));
  end
endmodule

bind xbar_cfg_ctrl xbar_cfg_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .upd_n(upd_n),
  .sw_ctrl(sw_ctrl), .out_en(out_en), .stage_q(stage_q)
);

// File: tb/test_xbar_cfg_ctrl.sv
module test_xbar_cfg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, ce_n, upd_n;
  logic [2:0]  addr;
  logic [4:0]  wdata;
  logic [79:0] sw_ctrl;
  logic [4:0]  out_en;

  int checks = 0;
  int fails  = 0;

  logic [4:0] m_stage [8];
  logic [3:0] m_sel [5];
  logic [4:0] m_en;

  always #5 clk = ~clk;

  xbar_cfg_ctrl i_xbar_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .upd_n(upd_n),
    .addr(addr), .wdata(wdata), .sw_ctrl(sw_ctrl), .out_en(out_en)
  );

  function automatic logic [79:0] exp_sw();
    logic [79:0] v = '0;
    for (int o = 0; o < 5; o++) if (m_en[o]) v[o*16 + int'(m_sel[o])] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [79:0] got, input logic [79:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " out_en"}, {75'd0, out_en}, {75'd0, m_en});
    check({req, " sw_ctrl"}, sw_ctrl, exp_sw());
  endtask

  task automatic stage_write(input logic [2:0] a, input logic [4:0] d);
    ce_n = 1'b0; upd_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    m_stage[a] = d;
    ce_n = 1'b1;
  endtask

  task automatic transfer();
    ce_n = 1'b0; upd_n = 1'b0;
    @(negedge clk);
    for (int o = 0; o < 5; o++) begin
      m_sel[o] = m_stage[o][3:0];
      m_en[o]  = m_stage[o][4];
    end
    upd_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic t_reset_state();
    check_all("R8 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) stage_write(3'(a), 5'd0);
    check_all("R9 enables stay off after release");
    transfer();
    check_all("R5 all disabled");
  endtask

  task automatic t_basic();
    stage_write(3'd0, 5'b1_0011);
    stage_write(3'd1, 5'b1_0000);
    stage_write(3'd2, 5'b1_1111);
    stage_write(3'd3, 5'b0_0110);
    stage_write(3'd4, 5'b1_1010);
    check_all("R4 staged writes hidden");
    transfer();
    check_all("R2 R5 R6 routing after transfer");
  endtask

  task automatic t_ce_freeze();
    logic [4:0] old0 = m_stage[0];
    ce_n = 1'b1; upd_n = 1'b1; addr = 3'd0; wdata = 5'b1_1100;
    @(negedge clk);
    upd_n = 1'b0; addr = 3'd1; wdata = 5'b0_0001;
    @(negedge clk);
    check_all("R1 ce high no transfer");
    transfer();
    check({"R1 location kept"}, {75'd0, out_en[0], sw_ctrl[3:0]},
          {75'd0, old0[4], 4'b1000});
    check_all("R1 staging unchanged");
  endtask

  task automatic t_open_no_write();
    ce_n = 1'b0; upd_n = 1'b0; addr = 3'd2; wdata = 5'b0_0000;
    @(negedge clk);
    @(negedge clk);
    check_all("R3 no write while latches open");
    upd_n = 1'b1; ce_n = 1'b1;
    stage_write(3'd3, 5'b1_0101);
    ce_n = 1'b0; upd_n = 1'b0;
    #2;
    m_sel[3] = 4'd5; m_en[3] = 1'b1;
    check_all("R3 transparent follow");
    @(negedge clk);
    upd_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic t_upper_locs();
    stage_write(3'd5, 5'b1_0001);
    stage_write(3'd6, 5'b1_0010);
    stage_write(3'd7, 5'b1_0100);
    transfer();
    check_all("R7 upper locations inert");
  endtask

  task automatic t_bounds();
    for (int o = 0; o < 5; o++) stage_write(3'(o), 5'b1_0000);
    transfer();
    check_all("R6 select 0 all outputs");
    for (int o = 0; o < 5; o++) stage_write(3'(o), 5'b1_1111);
    transfer();
    check_all("R6 select 15 all outputs");
    for (int o = 0; o < 5; o++) stage_write(3'(o), 5'b0_1001);
    transfer();
    check_all("R6 disabled with select");
    stage_write(3'd0, 5'b1_0111);
    stage_write(3'd1, 5'b0_0010);
    stage_write(3'd2, 5'b1_1000);
    stage_write(3'd3, 5'b1_0001);
    stage_write(3'd4, 5'b1_1110);
    transfer();
    check_all("R5 R6 mixed routing");
  endtask

  task automatic t_async_reset();
    logic [4:0] saved_en = m_en;
    #2 rst_n = 1'b0;
    #1;
    m_en = 5'd0;
    check_all("R8 async clear");
    @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_all("R9 off until transfer");
    m_en = saved_en;
    transfer();
    check_all("R8 selects and staging kept");
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; upd_n = 1'b1; addr = '0; wdata = '0;
    m_en = '0;
    for (int o = 0; o < 5; o++) m_sel[o] = '0;
    for (int a = 0; a < 8; a++) m_stage[a] = '0;
    @(negedge clk);
    @(negedge clk);
    t_reset_state();
    t_basic();
    t_ce_freeze();
    t_open_no_write();
    t_upper_locs();
    t_bounds();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule